// File: doc/BRIEF.md
# DRAM Clock-Frequency Change Sequencer

This block sits beside a memory controller during bring-up and answers its requests to change the DRAM clock. When `start` is pulsed, it reads the memory-class code. For one class it moves the clock to frequency point 1 and finishes at once. For the other class it parks the clock on the oscillator bypass and then serves a programmed number of frequency-change requests.

Each request arrives as a word that holds a valid flag and a type field. The block steers the clock generator through `clk_sel` and waits for the generator to report lock. It then runs a four-phase acknowledge with the controller. The wait for a request and the wait for the request to withdraw each have their own timeout. Both timeouts are counted in microsecond ticks.

Three sticky flags record problems:
- `err_fatal` marks a timeout, after which the block halts until reset.
- `err_invalid_req` marks a request of a reserved type.
- `err_class` marks an unknown memory class.

Top module: `freq_hs_seq`

## Requirements
- R1: After synchronous reset, `ack` is 0, `done` is 0, `clk_sel` is 0 (bypass) and all three error flags are 0.
- R2: On `start` with `mem_class` = 0xA, `clk_sel` becomes 1 (frequency point 1) and `done` pulses on the next clock, with no handshake (ack stays 0).
- R3: On `start` with `mem_class` = 0xB, `clk_sel` becomes 0 (bypass). If `hs_count` is 0, `done` pulses on the next clock; otherwise the handshake sequence begins.
- R4: On `start` with any other `mem_class`, `err_class` sets and stays set, `done` does not pulse and `clk_sel` is unchanged.
- R5: A request is valid when bit 7 of `req_word` is 1; its type is bits 1:0. Type 0 drives `clk_sel` = 0, type 1 drives 1 and type 2 drives 2. `clk_sel` never reads 3.
- R6: Type 3 sets the sticky `err_invalid_req` and leaves `clk_sel` unchanged, but the request is still acknowledged.
- R7: For type 1 or type 2, `ack` rises only after `clk_locked` is seen high. For type 0 or type 3, `ack` rises on the clock after the one that accepted the request.
- R8: `ack` stays high while the request stays valid, and falls on the clock after the valid flag is seen low.
- R9: If no valid request arrives within REQ_TMO_US ticks, `err_fatal` sets, `ack` is 0 and the block ignores all inputs until reset.
- R10: If the valid flag is still high DROP_TMO_US ticks after `ack` rises, `err_fatal` sets and `ack` drops to 0.
- R11: Exactly `hs_count` handshakes are served. `done` is a one-cycle pulse on the clock where `ack` falls for the last one.
- R12: Both timeouts advance only on cycles where `us_tick` is high, not on bare clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the sequence (sampled when idle) |
| mem_class | input | CLASS_W | Memory-class code |
| hs_count | input | CNT_W | Number of handshakes to serve |
| req_word | input | REQ_W | Request word: bit 7 valid, bits 1:0 type |
| us_tick | input | 1 | One-cycle microsecond tick |
| clk_locked | input | 1 | Clock generator lock indication |
| clk_sel | output | 2 | 0 bypass, 1 frequency point 1, 2 frequency point 2 |
| ack | output | 1 | Handshake acknowledge |
| done | output | 1 | One-cycle completion pulse |
| err_fatal | output | 1 | Sticky timeout error |
| err_invalid_req | output | 1 | Sticky reserved-request-type flag |
| err_class | output | 1 | Sticky unrecognized-class flag |

## Verification
The embedded assertions watch the following on every cycle:
- `done` is never longer than one clock.
- `ack` holds while a request stays valid.
- `ack` only rises after lock, bypass or an invalid type.
- The error flags never clear, and `ack` is low whenever the fatal flag is set.
- `clk_sel` never takes its unused code.
- Each timer holds still on cycles without a tick.

Only the bench's scenarios can show the exact cycle of each timeout at different tick rates, the order of clock choices across a multi-request run, the skip path for the 0xA class, and that `done` arrives after exactly the programmed number of handshakes.

// File: rtl/freq_hs_pkg.sv
package freq_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WREQ  = 3'd1,
    ST_WLOCK = 3'd2,
    ST_WDROP = 3'd3,
    ST_HALT  = 3'd4
  } hs_state_t;

  localparam logic [1:0] SEL_BYP = 2'd0;
  localparam logic [1:0] SEL_FP1 = 2'd1;
  localparam logic [1:0] SEL_FP2 = 2'd2;

endpackage

// File: rtl/hs_req_decode.sv
module hs_req_decode #(
  parameter int REQ_W     = 8,
  parameter int VALID_BIT = 7
) (
  input  logic [REQ_W-1:0] req_word,
  output logic             rq_valid,
  output logic [1:0]       rq_sel,
  output logic             rq_invalid,
  output logic             rq_bypass
);
  import freq_hs_pkg::*;

  logic [1:0] kind;

  always_comb begin
    rq_valid   = req_word[VALID_BIT];
    kind       = req_word[1:0];
    rq_invalid = (kind == 2'd3);
    rq_bypass  = (kind == 2'd0);
    case (kind)
      2'd1:    rq_sel = SEL_FP1;
      2'd2:    rq_sel = SEL_FP2;
      default: rq_sel = SEL_BYP;
    endcase
  end

endmodule

// File: rtl/hs_us_timer.sv
module hs_us_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && !expired)
      cnt <= cnt + 1'b1;
  end

  AST_TMR_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));  // R12

endmodule

// File: rtl/freq_hs_seq.sv
module freq_hs_seq #(
  parameter int                 CLASS_W     = 4,
  parameter logic [CLASS_W-1:0] CLASS_SKIP  = 'hA,
  parameter logic [CLASS_W-1:0] CLASS_HS    = 'hB,
  parameter int                 CNT_W       = 8,
  parameter int                 REQ_W       = 8,
  parameter int                 VALID_BIT   = 7,
  parameter int                 REQ_TMO_US  = 10000,
  parameter int                 DROP_TMO_US = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CLASS_W-1:0] mem_class,
  input  logic [CNT_W-1:0]   hs_count,
  input  logic [REQ_W-1:0]   req_word,
  input  logic               us_tick,
  input  logic               clk_locked,
  output logic [1:0]         clk_sel,
  output logic               ack,
  output logic               done,
  output logic               err_fatal,
  output logic               err_invalid_req,
  output logic               err_class
);
  import freq_hs_pkg::*;

  localparam int MAX_TMO = (REQ_TMO_US > DROP_TMO_US) ? REQ_TMO_US : DROP_TMO_US;
  localparam int TMR_W   = $clog2(MAX_TMO + 1);
  localparam logic [TMR_W-1:0] REQ_LIM  = TMR_W'(REQ_TMO_US);
  localparam logic [TMR_W-1:0] DROP_LIM = TMR_W'(DROP_TMO_US);

  hs_state_t        st, st_n;
  logic [CNT_W-1:0] left, left_n;
  logic             skip, skip_n;
  logic [1:0]       sel_n;
  logic             ack_n, done_n, fat_n, inv_n, cls_n;

  logic             rq_valid, rq_invalid, rq_bypass;
  logic [1:0]       rq_sel;
  logic             tmo;
  logic [TMR_W-1:0] lim;

  hs_req_decode #(.REQ_W(REQ_W), .VALID_BIT(VALID_BIT)) u_dec (
    .req_word   (req_word),
    .rq_valid   (rq_valid),
    .rq_sel     (rq_sel),
    .rq_invalid (rq_invalid),
    .rq_bypass  (rq_bypass)
  );

  assign lim = (st == ST_WDROP) ? DROP_LIM : REQ_LIM;

  hs_us_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (st_n != st),
    .tick    (us_tick),
    .limit   (lim),
    .expired (tmo)
  );

  always_comb begin
    st_n   = st;
    sel_n  = clk_sel;
    ack_n  = ack;
    done_n = 1'b0;
    fat_n  = err_fatal;
    inv_n  = err_invalid_req;
    cls_n  = err_class;
    left_n = left;
    skip_n = skip;
    case (st)
      ST_IDLE: begin
        if (start) begin
          if (mem_class == CLASS_SKIP) begin
            sel_n  = SEL_FP1;
            done_n = 1'b1;
          end else if (mem_class == CLASS_HS) begin
            sel_n = SEL_BYP;
            if (hs_count == '0)
              done_n = 1'b1;
            else begin
              left_n = hs_count;
              st_n   = ST_WREQ;
            end
          end else begin
            cls_n = 1'b1;
          end
        end
      end
      ST_WREQ: begin
        if (rq_valid) begin
          st_n   = ST_WLOCK;
          skip_n = rq_bypass || rq_invalid;
          if (rq_invalid) inv_n = 1'b1;
          else            sel_n = rq_sel;
        end else if (tmo) begin
          fat_n = 1'b1;
          st_n  = ST_HALT;
        end
      end
      ST_WLOCK: begin
        if (skip || clk_locked) begin
          ack_n = 1'b1;
          st_n  = ST_WDROP;
        end
      end
      ST_WDROP: begin
        if (!rq_valid) begin
          ack_n  = 1'b0;
          left_n = left - 1'b1;
          if (left == CNT_W'(1)) begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            st_n = ST_WREQ;
          end
        end else if (tmo) begin
          fat_n = 1'b1;
          ack_n = 1'b0;
          st_n  = ST_HALT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= ST_IDLE;
      clk_sel         <= SEL_BYP;
      ack             <= 1'b0;
      done            <= 1'b0;
      err_fatal       <= 1'b0;
      err_invalid_req <= 1'b0;
      err_class       <= 1'b0;
      left            <= '0;
      skip            <= 1'b0;
    end else begin
      st              <= st_n;
      clk_sel         <= sel_n;
      ack             <= ack_n;
      done            <= done_n;
      err_fatal       <= fat_n;
      err_invalid_req <= inv_n;
      err_class       <= cls_n;
      left            <= left_n;
      skip            <= skip_n;
    end
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    clk_sel != 2'd3);  // R5
  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_invalid_req |=> err_invalid_req);  // R6
  AST_CLASS_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_class |=> err_class);  // R4
  AST_ACK_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(clk_locked) || $past(clk_sel) == SEL_BYP || err_invalid_req));  // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack && req_word[VALID_BIT]) |=> (ack || err_fatal));  // R8
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_fatal |=> err_fatal);  // R9
  AST_FATAL_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    err_fatal |-> !ack);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R11

endmodule

// File: tb/tb_freq_hs_seq.sv
module tb_freq_hs_seq;

  localparam int REQ_TMO  = 10000;
  localparam int DROP_TMO = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] mem_class = 4'h0;
  logic [7:0] hs_count = 8'd0;
  logic [7:0] req_word = 8'h00;
  logic       us_tick = 1'b0;
  logic       clk_locked = 1'b1;
  logic [1:0] clk_sel;
  logic       ack, done, err_fatal, err_invalid_req, err_class;

  int n_chk = 0;
  int n_fail = 0;
  int tdiv = 1;
  int cyc = 0;
  int lock_cnt = 0;
  logic [1:0] prev_sel = 2'd0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  freq_hs_seq #(.REQ_TMO_US(REQ_TMO), .DROP_TMO_US(DROP_TMO)) dut (
    .clk(clk), .rst(rst), .start(start), .mem_class(mem_class),
    .hs_count(hs_count), .req_word(req_word), .us_tick(us_tick),
    .clk_locked(clk_locked), .clk_sel(clk_sel), .ack(ack), .done(done),
    .err_fatal(err_fatal), .err_invalid_req(err_invalid_req), .err_class(err_class)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // tick source and clock-generator lock model
  always @(negedge clk) begin
    cyc++;
    us_tick <= ((cyc % tdiv) == 0);
    if (clk_sel !== prev_sel) begin
      lock_cnt = 3;
      clk_locked <= 1'b0;
    end else if (lock_cnt > 0) begin
      lock_cnt--;
      clk_locked <= (lock_cnt == 0);
    end
    prev_sel = clk_sel;
  end

  // behavioural reference model
  int m_ph, m_left, m_t, m_sel;
  bit m_ack, m_done, m_fat, m_inv, m_cls, m_skip;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_sel = 0; m_ack = 0; m_done = 0; m_fat = 0; m_inv = 0;
      m_cls = 0; m_left = 0; m_t = 0; m_skip = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin
          if (mem_class == 4'hA) begin m_sel = 1; m_done = 1; end
          else if (mem_class == 4'hB) begin
            m_sel = 0;
            if (hs_count == 0) m_done = 1;
            else begin m_left = hs_count; m_ph = 1; m_t = 0; end
          end else m_cls = 1;
        end
      end else if (m_ph == 1) begin
        if (req_word[7]) begin
          if (req_word[1:0] == 2'd3) begin m_inv = 1; m_skip = 1; end
          else begin m_sel = req_word[1:0]; m_skip = (req_word[1:0] == 2'd0); end
          m_ph = 2;
        end else if (m_t >= REQ_TMO) begin m_fat = 1; m_ph = 4; end
        else if (us_tick) m_t++;
      end else if (m_ph == 2) begin
        if (m_skip || clk_locked) begin m_ack = 1; m_ph = 3; m_t = 0; end
      end else if (m_ph == 3) begin
        if (!req_word[7]) begin
          m_ack = 0; m_left--;
          if (m_left == 0) begin m_done = 1; m_ph = 0; end
          else begin m_ph = 1; m_t = 0; end
        end else if (m_t >= DROP_TMO) begin m_fat = 1; m_ack = 0; m_ph = 4; end
        else if (us_tick) m_t++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(clk_sel == 2'(m_sel), "R5 clk_sel vs model", clk_sel, m_sel);
      chk(ack == m_ack, "R8 ack vs model", ack, m_ack);
      chk(done == m_done, "R11 done vs model", done, m_done);
      chk(err_fatal == m_fat, "R9 err_fatal vs model", err_fatal, m_fat);
      chk(err_invalid_req == m_inv, "R6 err_invalid_req vs model", err_invalid_req, m_inv);
      chk(err_class == m_cls, "R4 err_class vs model", err_class, m_cls);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; start = 0; req_word = 8'h00; tdiv = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_en = 1;
  endtask

  task automatic kick(input logic [3:0] cls, input logic [7:0] cnt);
    @(negedge clk);
    start = 1; mem_class = cls; hs_count = cnt;
    @(negedge clk);
    start = 0;
  endtask

  task automatic serve(input logic [1:0] kind, input int exp_sel, input bit locked_path, input bit last);
    int n;
    @(negedge clk);
    req_word = 8'h80 | 8'(kind);
    n = 0;
    do begin @(negedge clk); n++; end while (!ack && n < 100);
    if (locked_path) chk(n >= 4, "R7 ack waited for lock", n, 5);
    else             chk(n == 2, "R7 ack without lock wait", n, 2);
    chk(clk_sel == 2'(exp_sel), "R5 clock choice for type", clk_sel, exp_sel);
    if (kind == 2'd3) chk(err_invalid_req == 1'b1, "R6 reserved type flagged", err_invalid_req, 1);
    req_word = 8'(kind);
    n = 0;
    do begin @(negedge clk); n++; end while (ack && n < 100);
    chk(n == 1, "R8 ack falls after valid drops", n, 1);
    chk(done == last, "R11 done after last handshake only", done, last);
  endtask

  initial begin
    int n;
    do_reset();
    chk(ack == 0 && done == 0 && clk_sel == 0, "R1 outputs after reset", {ack, done, clk_sel}, 0);
    chk(!err_fatal && !err_invalid_req && !err_class, "R1 flags after reset",
        {err_fatal, err_invalid_req, err_class}, 0);

    kick(4'hA, 8'd3);
    chk(clk_sel == 2'd1, "R2 class A picks point 1", clk_sel, 1);
    chk(done == 1'b1, "R2 class A done at once", done, 1);
    @(negedge clk);
    chk(ack == 1'b0 && done == 1'b0, "R2 no handshake for class A", {ack, done}, 0);

    kick(4'hB, 8'd0);
    chk(clk_sel == 2'd0, "R3 class B picks bypass", clk_sel, 0);
    chk(done == 1'b1, "R3 zero count completes at once", done, 1);

    kick(4'h5, 8'd2);
    chk(err_class == 1'b1, "R4 unknown class flagged", err_class, 1);
    chk(done == 1'b0 && clk_sel == 2'd0, "R4 no done, clock kept", {done, clk_sel}, 0);

    do_reset();
    kick(4'hB, 8'd4);
    serve(2'd1, 1, 1, 0);
    serve(2'd2, 2, 1, 0);
    serve(2'd3, 2, 0, 0);
    serve(2'd0, 0, 0, 1);

    do_reset();
    tdiv = 4;
    kick(4'hB, 8'd1);
    n = 0;
    while (!err_fatal && n < 50000) begin @(negedge clk); n++; end
    chk(n >= 4 * REQ_TMO - 8 && n <= 4 * REQ_TMO + 8, "R12 request timeout in ticks", n, 4 * REQ_TMO);
    chk(err_fatal == 1'b1 && ack == 1'b0, "R9 request timeout is fatal", {err_fatal, ack}, 2);
    @(negedge clk); req_word = 8'h81;
    repeat (10) @(negedge clk);
    chk(ack == 1'b0 && clk_sel == 2'd0, "R9 halted after timeout", {ack, clk_sel}, 0);

    do_reset();
    kick(4'hB, 8'd1);
    @(negedge clk); req_word = 8'h80;
    n = 0;
    do begin @(negedge clk); n++; end while (!ack && n < 100);
    n = 0;
    while (!err_fatal && n < 100) begin @(negedge clk); n++; end
    chk(n >= DROP_TMO && n <= DROP_TMO + 3, "R10 withdraw timeout", n, DROP_TMO + 1);
    chk(ack == 1'b0, "R10 ack dropped on timeout", ack, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule